// File: doc/BRIEF.md
# Chained Transfer Descriptor Loader

This block sits beside one DMA channel and keeps it fed with work. It holds the channel's five working registers: source address, destination address, next-descriptor pointer, control word and transfer count. When the channel reports that its transfer is complete, the block reads the next-descriptor pointer. A pointer whose address bits are all zero ends the chain. Any other pointer makes the block read a five-word descriptor from memory through a simple request/acknowledge read port. When all five words are in, it copies them into the working registers and enables the channel again.

Software starts a chain by writing the working registers directly while the block is idle and then pulsing a start input. While the channel runs, software may rewrite the live next-pointer register to hang a new descriptor onto the end of a running chain. A chain whose last descriptor points back to its first repeats without end. A read that returns an error stops the chain with the channel disabled and raises a one-cycle error pulse.

States: IDLE (channel off, direct writes accepted), RUN (channel enabled, waiting for done), FETCH (one descriptor word requested at a time), LOAD (staged words copied into the working registers). Transitions: IDLE→RUN on start. RUN→IDLE on done with a zero pointer (chain end). RUN→FETCH on done with a nonzero pointer. FETCH→FETCH on each good word before the fifth. FETCH→LOAD on the fifth good word. FETCH→IDLE on a read error. LOAD→RUN always.

Top module: `dll_loader`

## Requirements
- R1: After reset the channel enable, read request, error pulse and chain-end pulse are low, and all five working registers read zero.
- R2: While idle, a write with select 0 (source), 1 (destination), 2 (next pointer), 3 (control) or 4 (count) updates that register on the next clock edge. Selects 5 to 7 change nothing. A start pulse raises the channel enable on the next edge.
- R3: On done, a next pointer whose bits 31:2 are all zero drops the channel enable on the next edge and raises the chain-end pulse for exactly one cycle. No memory read is issued.
- R4: On done, a nonzero next pointer drops the channel enable and starts five reads. They go to the pointer with bits 1:0 cleared, then to +4, +8, +12 and +16, in that order. Each read has the master select equal to pointer bit 0. Only one read is outstanding, and its request and address hold until it is acknowledged.
- R5: The working registers keep their old values during a fetch. After the fifth word is accepted, all five are loaded together with word 0 as source, word 1 as destination, word 2 as next pointer, word 3 as control and word 4 as count. The channel enable rises in the same cycle.
- R6: A next-pointer write while running decides the next fetch if it arrives before done. A write in the same cycle as done is the pointer used.
- R7: While running, writes to any register other than the next pointer are ignored. During a fetch or load, all writes and start pulses are ignored.
- R8: A read acknowledged with an error ends the fetch. The error pulse is high for one cycle, the channel stays disabled, the working registers keep their old values and no further reads are issued.
- R9: A circular chain, whose last descriptor points back to its first, keeps fetching and running for as many rounds as done keeps arriving.
- R10: A done pulse while idle starts no read and does not enable the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr_en | input | 1 | Direct register write strobe |
| sw_wr_sel | input | 3 | Register select for the direct write |
| sw_wr_data | input | DATA_W | Direct write data |
| sw_start | input | 1 | Start the channel from idle |
| chan_done | input | 1 | Current transfer complete |
| chan_en | output | 1 | Channel enable |
| reg_src | output | DATA_W | Working source address |
| reg_dst | output | DATA_W | Working destination address |
| reg_next | output | DATA_W | Working next-descriptor pointer |
| reg_ctl | output | DATA_W | Working control word |
| reg_cnt | output | DATA_W | Working transfer count |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | DATA_W | Memory read address |
| rd_master | output | 1 | Bus master select for the read |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | DATA_W | Read data |
| rd_err | input | 1 | Read error, valid with rd_ack |
| err_pulse | output | 1 | One-cycle read error indication |
| chain_end | output | 1 | One-cycle end-of-chain indication |

## Verification
A wrong word index shows up at the read port as an out-of-order address on the next acknowledged read. A staging slot that is mis-steered appears in the working registers in the cycle the enable returns. A state that is left too early shows as the enable rising while a request is still open, or as registers that change during a fetch. Either is visible within one cycle. A lost pointer patch or a stale pointer sample shows as a fetch from the wrong base on the first read after done.

// File: rtl/dll_pkg.sv
package dll_pkg;

    localparam int DESC_WORDS = 5;
    localparam int SLOT_NEXT  = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FETCH = 2'd2,
        ST_LOAD  = 2'd3
    } ldr_state_t;

endpackage

// File: rtl/dll_fsm.sv
module dll_fsm
    import dll_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NWORDS = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sw_start,
    input  logic                      chan_done,
    input  logic [DATA_W-1:0]         next_eff,
    input  logic                      rd_ack,
    input  logic                      rd_err,
    output ldr_state_t                state,
    output logic [$clog2(NWORDS)-1:0] word_idx,
    output logic                      cap_en,
    output logic                      load_en,
    output logic                      chan_en,
    output logic                      rd_req,
    output logic [DATA_W-1:0]         rd_addr,
    output logic                      rd_master,
    output logic                      err_pulse,
    output logic                      chain_end
);
    localparam int                IDX_W    = $clog2(NWORDS);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NWORDS - 1);
    localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'(3);

    ldr_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] base_q;
    logic              master_q;
    logic              err_q, end_q;
    logic              ptr_zero;

    assign ptr_zero = ((next_eff >> 2) == '0);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sw_start) state_d = ST_RUN;
            ST_RUN:   if (chan_done) state_d = ptr_zero ? ST_IDLE : ST_FETCH;
            ST_FETCH: begin
                if (rd_ack) begin
                    if (rd_err)                 state_d = ST_IDLE;
                    else if (idx_q == LAST_IDX) state_d = ST_LOAD;
                end
            end
            ST_LOAD:  state_d = ST_RUN;
        endcase
    end

    // state register and its companions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            base_q   <= '0;
            master_q <= 1'b0;
            err_q    <= 1'b0;
            end_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= (state_q == ST_FETCH) && rd_ack && rd_err;
            end_q   <= (state_q == ST_RUN) && chan_done && ptr_zero;
            if ((state_q == ST_RUN) && chan_done && !ptr_zero) begin
                base_q   <= next_eff & ~LOW_MASK;
                master_q <= next_eff[0];
                idx_q    <= '0;
            end else if ((state_q == ST_FETCH) && rd_ack && !rd_err && (idx_q != LAST_IDX)) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        chan_en   = 1'b0;
        rd_req    = 1'b0;
        cap_en    = 1'b0;
        load_en   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_RUN:   chan_en = 1'b1;
            ST_FETCH: begin
                rd_req = 1'b1;
                cap_en = rd_ack && !rd_err;
            end
            ST_LOAD:  load_en = 1'b1;
        endcase
        rd_addr   = base_q + DATA_W'({idx_q, 2'b00});
        rd_master = master_q;
        err_pulse = err_q;
        chain_end = end_q;
        state     = state_q;
        word_idx  = idx_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))) else $error("request dropped"); // R4
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[1:0] == 2'b00)) else $error("misaligned read"); // R4
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse) else $error("error pulse too long"); // R8
    AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        chain_end |=> !chain_end) else $error("end pulse too long"); // R3
    AST_END_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        chain_end |-> (!rd_req && !chan_en)) else $error("activity at chain end"); // R3
endmodule

// File: rtl/dll_desc_buf.sv
module dll_desc_buf #(
    parameter int DATA_W = 32,
    parameter int NWORDS = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cap_en,
    input  logic [$clog2(NWORDS)-1:0]      cap_idx,
    input  logic [DATA_W-1:0]              cap_data,
    output logic [NWORDS-1:0][DATA_W-1:0]  words
);
    localparam int IDX_W = $clog2(NWORDS);

    for (genvar g = 0; g < NWORDS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[g] <= '0;
            else if (cap_en && (cap_idx == IDX_W'(g)))
                words[g] <= cap_data;
        end
    end
endmodule

// File: rtl/dll_chan_regs.sv
module dll_chan_regs
    import dll_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NWORDS = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  ldr_state_t                     state,
    input  logic                           sw_wr_en,
    input  logic [2:0]                     sw_wr_sel,
    input  logic [DATA_W-1:0]              sw_wr_data,
    input  logic                           load_en,
    input  logic [NWORDS-1:0][DATA_W-1:0]  load_words,
    output logic [NWORDS-1:0][DATA_W-1:0]  regs,
    output logic [DATA_W-1:0]              next_eff
);
    logic running, idle;
    assign running = (state == ST_RUN);
    assign idle    = (state == ST_IDLE);

    for (genvar g = 0; g < NWORDS; g++) begin : g_reg
        logic hit, allowed;
        assign hit     = sw_wr_en && (sw_wr_sel == 3'(g));
        assign allowed = idle || (running && (g == SLOT_NEXT));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (load_en)
                regs[g] <= load_words[g];
            else if (hit && allowed)
                regs[g] <= sw_wr_data;
        end
    end

    // a pointer patch landing with done is the one the fetch uses
    assign next_eff = (running && sw_wr_en && (sw_wr_sel == 3'(SLOT_NEXT)))
                      ? sw_wr_data : regs[SLOT_NEXT];

    AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> $stable(regs)) else $error("registers moved during fetch"); // R5
    AST_RUN_ONLY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> ($stable(regs[0]) && $stable(regs[1]))) else $error("run write leaked"); // R7
endmodule

// File: rtl/dll_loader.sv
module dll_loader
    import dll_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr_en,
    input  logic [2:0]        sw_wr_sel,
    input  logic [DATA_W-1:0] sw_wr_data,
    input  logic              sw_start,
    input  logic              chan_done,
    output logic              chan_en,
    output logic [DATA_W-1:0] reg_src,
    output logic [DATA_W-1:0] reg_dst,
    output logic [DATA_W-1:0] reg_next,
    output logic [DATA_W-1:0] reg_ctl,
    output logic [DATA_W-1:0] reg_cnt,
    output logic              rd_req,
    output logic [DATA_W-1:0] rd_addr,
    output logic              rd_master,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_err,
    output logic              err_pulse,
    output logic              chain_end
);
    localparam int NWORDS = DESC_WORDS;
    localparam int IDX_W  = $clog2(NWORDS);

    ldr_state_t                    state;
    logic [IDX_W-1:0]              word_idx;
    logic                          cap_en, load_en;
    logic [NWORDS-1:0][DATA_W-1:0] staged, regs;
    logic [DATA_W-1:0]             next_eff;

    dll_fsm #(.DATA_W(DATA_W), .NWORDS(NWORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .chan_done(chan_done),
        .next_eff(next_eff), .rd_ack(rd_ack), .rd_err(rd_err),
        .state(state), .word_idx(word_idx), .cap_en(cap_en), .load_en(load_en),
        .chan_en(chan_en), .rd_req(rd_req), .rd_addr(rd_addr), .rd_master(rd_master),
        .err_pulse(err_pulse), .chain_end(chain_end)
    );

    dll_desc_buf #(.DATA_W(DATA_W), .NWORDS(NWORDS)) u_buf (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(word_idx),
        .cap_data(rd_data), .words(staged)
    );

    dll_chan_regs #(.DATA_W(DATA_W), .NWORDS(NWORDS)) u_regs (
        .clk(clk), .rst_n(rst_n), .state(state), .sw_wr_en(sw_wr_en),
        .sw_wr_sel(sw_wr_sel), .sw_wr_data(sw_wr_data), .load_en(load_en),
        .load_words(staged), .regs(regs), .next_eff(next_eff)
    );

    assign reg_src  = regs[0];
    assign reg_dst  = regs[1];
    assign reg_next = regs[2];
    assign reg_ctl  = regs[3];
    assign reg_cnt  = regs[4];

    AST_NO_RUN_WHILE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !chan_en) else $error("enabled during fetch"); // R4
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (!chan_en && !rd_req)) else $error("active after error"); // R8
    AST_ENABLE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !$past(chan_en) && !$past(sw_start)) |-> $past(!rd_req)) else $error("enable without load"); // R5
endmodule

// File: tb/dll_loader_tb.sv
module dll_loader_tb;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_wr_en = 1'b0;
    logic [2:0]    sw_wr_sel = '0;
    logic [DW-1:0] sw_wr_data = '0;
    logic          sw_start = 1'b0;
    logic          chan_done = 1'b0;
    logic          chan_en;
    logic [DW-1:0] reg_src, reg_dst, reg_next, reg_ctl, reg_cnt;
    logic          rd_req, rd_master;
    logic [DW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          rd_err = 1'b0;
    logic          err_pulse, chain_end;

    always #5 clk = ~clk;

    dll_loader #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel),
        .sw_wr_data(sw_wr_data), .sw_start(sw_start), .chan_done(chan_done),
        .chan_en(chan_en), .reg_src(reg_src), .reg_dst(reg_dst), .reg_next(reg_next),
        .reg_ctl(reg_ctl), .reg_cnt(reg_cnt), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_master(rd_master), .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
        .err_pulse(err_pulse), .chain_end(chain_end)
    );

    int checks = 0;
    int errors = 0;
    int reads = 0;
    int err_seen = 0;
    int end_seen = 0;
    logic [DW-1:0] mem [64];
    logic [DW-1:0] err_addr = 32'hFFFF_FFFF;
    logic [DW:0]   exp_q [$];

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model and read scoreboard monitor
    always @(negedge clk) begin
        if (rd_ack) begin
            rd_ack = 1'b0;
            rd_err = 1'b0;
        end else if (rd_req) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected read", rd_addr, 32'hFFFF_FFFF);
            end else begin
                logic [DW:0] e;
                e = exp_q.pop_front();
                chk("R4 read address", rd_addr, e[DW-1:0]);
                chk("R4 read master", {31'd0, rd_master}, {31'd0, e[DW]});
            end
            rd_data = mem[rd_addr[7:2]];
            rd_err  = (rd_addr == err_addr);
            rd_ack  = 1'b1;
            reads++;
        end
    end

    always @(negedge clk) begin
        if (err_pulse) err_seen++;
        if (chain_end) end_seen++;
    end

    task automatic set_desc(input logic [7:0] base, input logic [DW-1:0] s, d, n, c, k);
        mem[base[7:2]]     = s;
        mem[base[7:2] + 1] = d;
        mem[base[7:2] + 2] = n;
        mem[base[7:2] + 3] = c;
        mem[base[7:2] + 4] = k;
    endtask

    task automatic push_desc(input logic [DW-1:0] ptr, input int nwords);
        for (int i = 0; i < nwords; i++)
            exp_q.push_back({ptr[0], (ptr & ~32'd3) + 32'(4 * i)});
    endtask

    task automatic sw_write(input logic [2:0] sel, input logic [DW-1:0] data);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_sel = sel; sw_wr_data = data;
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    task automatic start_ch();
        @(negedge clk);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
    endtask

    task automatic direct_setup(input logic [DW-1:0] s, input logic [DW-1:0] n);
        sw_write(3'd0, s);
        sw_write(3'd1, s + 32'h100);
        sw_write(3'd2, n);
        sw_write(3'd3, 32'h0000_00C3);
        sw_write(3'd4, 32'h0000_0040);
    endtask

    // done pulse, wait for reload, check held and loaded registers
    task automatic fetch_run(input logic [DW-1:0] ptr, input bit poke, input string tag);
        logic [DW-1:0] old_src;
        logic [DW-1:0] b;
        bit held = 1'b1;
        int n = 0;
        old_src = reg_src;
        b = (ptr & ~32'd3);
        push_desc(ptr, 5);
        @(negedge clk);
        chan_done = 1'b1;
        @(negedge clk);
        chan_done = 1'b0;
        while (!chan_en && n < 100) begin
            if (reg_src !== old_src) held = 1'b0;
            if (poke && n == 2) begin sw_wr_en = 1'b1; sw_wr_sel = 3'd0; sw_wr_data = 32'hBAD0_BAD0; end
            else sw_wr_en = 1'b0;
            @(negedge clk);
            n++;
        end
        sw_wr_en = 1'b0;
        chk({tag, " R5 regs held during fetch"}, {31'd0, held}, 32'd1);
        chk({tag, " R5 enable back"}, {31'd0, chan_en}, 32'd1);
        chk({tag, " R5 src"}, reg_src, mem[b[7:2]]);
        chk({tag, " R5 dst"}, reg_dst, mem[b[7:2] + 1]);
        chk({tag, " R5 next"}, reg_next, mem[b[7:2] + 2]);
        chk({tag, " R5 ctl"}, reg_ctl, mem[b[7:2] + 3]);
        chk({tag, " R5 cnt"}, reg_cnt, mem[b[7:2] + 4]);
    endtask

    task automatic end_done(input string tag);
        int e0, r0;
        e0 = end_seen; r0 = reads;
        @(negedge clk);
        chan_done = 1'b1;
        @(negedge clk);
        chan_done = 1'b0;
        chk({tag, " R3 enable low"}, {31'd0, chan_en}, 32'd0);
        repeat (4) @(negedge clk);
        chk({tag, " R3 one end pulse"}, 32'(end_seen - e0), 32'd1);
        chk({tag, " R3 no read"}, 32'(reads - r0), 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h5A00_0000 + 32'(i);
        set_desc(8'h20, 32'hA0A0_0010, 32'hD0D0_0010, 32'h0000_0040, 32'hC0C0_0001, 32'h0000_0100);
        set_desc(8'h40, 32'hA0A0_0020, 32'hD0D0_0020, 32'h0000_0000, 32'hC0C0_0002, 32'h0000_0200);
        set_desc(8'h80, 32'hA0A0_0030, 32'hD0D0_0030, 32'h0000_00A0, 32'hC0C0_0003, 32'h0000_0300);
        set_desc(8'hA0, 32'hA0A0_0040, 32'hD0D0_0040, 32'h0000_0081, 32'hC0C0_0004, 32'h0000_0400);

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 chan_en", {31'd0, chan_en}, 32'd0);
        chk("R1 rd_req", {31'd0, rd_req}, 32'd0);
        chk("R1 pulses", {30'd0, err_pulse, chain_end}, 32'd0);
        chk("R1 regs", reg_src | reg_dst | reg_next | reg_ctl | reg_cnt, 32'd0);
        rst_n = 1'b1;

        // R2 direct writes and start; select 5 ignored
        direct_setup(32'h1000_0000, 32'h0);
        sw_write(3'd5, 32'hFFFF_FFFF);
        chk("R2 src", reg_src, 32'h1000_0000);
        chk("R2 dst", reg_dst, 32'h1000_0100);
        chk("R2 ctl", reg_ctl, 32'h0000_00C3);
        chk("R2 cnt", reg_cnt, 32'h0000_0040);
        chk("R2 next", reg_next, 32'h0);
        start_ch();
        chk("R2 enable after start", {31'd0, chan_en}, 32'd1);
        // R3 zero pointer ends the chain
        end_done("zero");

        // R4/R5 two-step chain with master bit; R7 write during fetch ignored
        direct_setup(32'h2000_0000, 32'h0000_0021);
        start_ch();
        fetch_run(32'h0000_0021, 1'b1, "chainA");
        // R7 writes other than next ignored while running
        sw_write(3'd0, 32'hDEAD_0000);
        sw_write(3'd4, 32'hDEAD_0004);
        chk("R7 src kept", reg_src, 32'hA0A0_0010);
        chk("R7 cnt kept", reg_cnt, 32'h0000_0100);
        fetch_run(32'h0000_0040, 1'b0, "chainB");
        end_done("chainB");

        // R6 patch next while running
        direct_setup(32'h3000_0000, 32'h0);
        start_ch();
        sw_write(3'd2, 32'h0000_0040);
        chk("R6 patch visible", reg_next, 32'h0000_0040);
        fetch_run(32'h0000_0040, 1'b0, "patch");
        // R6 same-cycle patch: write with done
        begin
            push_desc(32'h0000_0020, 5);
            @(negedge clk);
            chan_done = 1'b1; sw_wr_en = 1'b1; sw_wr_sel = 3'd2; sw_wr_data = 32'h0000_0020;
            @(negedge clk);
            chan_done = 1'b0; sw_wr_en = 1'b0;
            for (int n = 0; n < 100 && !chan_en; n++) @(negedge clk);
            chk("R6 same-cycle patch src", reg_src, 32'hA0A0_0010);
        end
        fetch_run(32'h0000_0040, 1'b0, "afterpatch");
        end_done("afterpatch");

        // R9 circular chain, three rounds
        direct_setup(32'h4000_0000, 32'h0000_0080);
        start_ch();
        for (int lap = 0; lap < 3; lap++) begin
            fetch_run((lap == 0) ? 32'h0000_0080 : 32'h0000_0081, 1'b0, "R9 ringC");
            fetch_run(32'h0000_00A0, 1'b0, "R9 ringD");
        end
        chk("R9 still running", {31'd0, chan_en}, 32'd1);
        sw_write(3'd2, 32'h0);
        end_done("R9 break");

        // R10 done while idle
        begin
            int r0;
            r0 = reads;
            @(negedge clk); chan_done = 1'b1;
            @(negedge clk); chan_done = 1'b0;
            repeat (4) @(negedge clk);
            chk("R10 no read", 32'(reads - r0), 32'd0);
            chk("R10 stays off", {31'd0, chan_en}, 32'd0);
        end

        // R8 read error on third word
        err_addr = 32'h0000_0048;
        direct_setup(32'h5000_0000, 32'h0000_0040);
        start_ch();
        begin
            int e0, r0;
            e0 = err_seen;
            push_desc(32'h0000_0040, 3);
            @(negedge clk); chan_done = 1'b1;
            @(negedge clk); chan_done = 1'b0;
            for (int n = 0; n < 100 && err_seen == e0; n++) @(negedge clk);
            r0 = reads;
            repeat (6) @(negedge clk);
            chk("R8 one error pulse", 32'(err_seen - e0), 32'd1);
            chk("R8 channel off", {31'd0, chan_en}, 32'd0);
            chk("R8 no more reads", 32'(reads - r0), 32'd0);
            chk("R8 src kept", reg_src, 32'h5000_0000);
            chk("R8 next kept", reg_next, 32'h0000_0040);
        end
        chk("R4 all expected reads seen", 32'(exp_q.size()), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule